// File: doc/BRIEF.md
# ADC Sync and Serial-Reset Sequencer

This block produces the two maintenance sequences a delta-sigma converter needs from its host. A sync request pulls the converter's active-low synchronisation pin low for a fixed number of clock cycles and then releases it. A reset request takes over the serial clock line and plays a pattern of three high pulses, each longer than the one before. The converter decodes that pattern as a serial reset command. Both sequences count time on one shared down-counter. The block is clocked at the converter master-clock rate, so one cycle equals one master-clock period.

While a sequence runs, the block raises `busy`, ignores further requests, and asserts `sclk_own`. That signal tells the serial-clock multiplexer to take SCLK from `sclk_out` and not from the normal serial master. When a sequence ends, `done` pulses for one cycle and SCLK control goes back to the master. With `USE_CS` set, chip select is driven low for the length of each sequence, which is what a chip-select-framed link requires. With `USE_CS` clear, chip select is tied low, as on a link where it is hardwired.

The controller has five states:
- `ST_IDLE`
- `ST_SYNC_LO` (sync pin held low)
- `ST_RST_HI` (an SCLK high pulse)
- `ST_RST_LO` (an SCLK low gap)
- `ST_DONE` (a single completion cycle)

Its transitions are:
- IDLE→SYNC_LO on a sync request.
- IDLE→RST_HI on a reset request when no sync request is present.
- SYNC_LO→DONE when the timer expires.
- RST_HI→RST_LO when the timer expires.
- RST_LO→RST_HI when the timer expires and fewer than three pulses have been sent.
- RST_LO→DONE when the timer expires after the third pulse.
- DONE→IDLE unconditionally.

Top module: `adc_maint_seq`

## Requirements
- R1: After reset the outputs read `busy`=0, `done`=0, `sync_n`=1, `sclk_out`=0 and `sclk_own`=0. `cs_n`=1 when `USE_CS`=1.
- R2: A sync request accepted in idle drives `sync_n` low for exactly `SYNC_CYCLES` cycles (default 1200), starting in the cycle after the request is sampled, and then returns it high.
- R3: A reset request accepted in idle drives `sclk_out` with three high pulses lasting `PULSE0`, `PULSE1` and `PULSE2` cycles (defaults 256, 512, 1024), in that order.
- R4: `sclk_out` is low for exactly `GAP_CYCLES` cycles (default 4) after each of the three pulses, including the last.
- R5: `busy` is 1 from the first cycle of a sequence through its `done` cycle. Any request seen while `busy` is 1 is ignored and does not alter or extend the running sequence.
- R6: `done` is 1 for exactly one cycle, immediately after the last active cycle of either sequence. `busy` is 0 in the following cycle.
- R7: `sclk_own` equals `busy`. When `sclk_own` is 0, `sclk_out` is 0.
- R8: With `USE_CS`=1, `cs_n` is 0 during the `sync_n`-low cycles and during all pulse and gap cycles of the reset pattern. It is 1 in idle and in the `done` cycle.
- R9: If both requests are sampled high in the same idle cycle, the sync sequence runs and the reset request is dropped.
- R10: `sclk_out` stays 0 throughout a sync sequence, and `sync_n` stays 1 throughout a reset sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the converter master-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_req | input | 1 | Start the sync sequence (sampled in idle) |
| reset_req | input | 1 | Start the serial-reset pattern (sampled in idle) |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| sync_n | output | 1 | Active-low sync pin drive |
| sclk_out | output | 1 | Serial clock value while the block owns SCLK |
| sclk_own | output | 1 | 1 = SCLK mux selects `sclk_out`, 0 = serial master owns SCLK |
| cs_n | output | 1 | Active-low chip select |

## Verification
A request sampled at a rising edge moves the state register at that same edge. Every output is decoded straight from the state, so the first active cycle is the cycle that follows the sampling edge. The bench drives requests on falling edges and samples on falling edges, which means every count it makes lines up with whole state cycles. Pulse and gap lengths are measured as run lengths over consecutive falling-edge samples. `done` is expected on the first sample after the last run, and `busy` is expected low one sample later. Requests that land mid-sequence are checked by confirming that the run lengths, the quiet output and the completion point do not change.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SYNC_LO = 3'd1,
        ST_RST_HI  = 3'd2,
        ST_RST_LO  = 3'd3,
        ST_DONE    = 3'd4
    } seq_state_t;

    localparam int unsigned NUM_PULSES = 3;
    localparam int unsigned IDX_W      = 2;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign expired = (count == '0);

    // the counter parks at zero rather than wrapping
    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count == '0) |=> (count == '0));  // R2

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count != '0) |=> (count == $past(count) - 1'b1));  // R3

endmodule

// File: rtl/pulse_len_sel.sv
module pulse_len_sel
    import seqr_pkg::*;
#(
    parameter int unsigned CNT_W  = 11,
    parameter int unsigned PULSE0 = 256,
    parameter int unsigned PULSE1 = 512,
    parameter int unsigned PULSE2 = 1024
) (
    input  logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] len_m1
);

    always_comb begin
        unique case (idx)
            2'd0:    len_m1 = CNT_W'(PULSE0 - 1);
            2'd1:    len_m1 = CNT_W'(PULSE1 - 1);
            default: len_m1 = CNT_W'(PULSE2 - 1);
        endcase
    end

endmodule

// File: rtl/cs_frame.sv
module cs_frame #(
    parameter bit USE_CS = 1'b1
) (
    input  logic active,
    output logic cs_n
);

    generate
        if (USE_CS) begin : g_framed
            assign cs_n = ~active;
        end else begin : g_tied
            logic unused_active;
            assign unused_active = active;
            assign cs_n = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/adc_maint_seq.sv
module adc_maint_seq
    import seqr_pkg::*;
#(
    parameter int unsigned SYNC_CYCLES = 1200,
    parameter int unsigned PULSE0      = 256,
    parameter int unsigned PULSE1      = 512,
    parameter int unsigned PULSE2      = 1024,
    parameter int unsigned GAP_CYCLES  = 4,
    parameter bit          USE_CS      = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_req,
    input  logic reset_req,
    output logic busy,
    output logic done,
    output logic sync_n,
    output logic sclk_out,
    output logic sclk_own,
    output logic cs_n
);

    localparam int unsigned MAX_LEN =
        max2(max2(SYNC_CYCLES, GAP_CYCLES), max2(max2(PULSE0, PULSE1), PULSE2));
    localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PULSES - 1);

    seq_state_t       state, state_nx;
    logic [IDX_W-1:0] idx, idx_nx;
    logic [IDX_W-1:0] sel_idx;
    logic [CNT_W-1:0] pulse_m1;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             seq_active;

    seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    pulse_len_sel #(
        .CNT_W (CNT_W),
        .PULSE0(PULSE0),
        .PULSE1(PULSE1),
        .PULSE2(PULSE2)
    ) u_len (
        .idx    (sel_idx),
        .len_m1 (pulse_m1)
    );

    // in idle the first pulse is selected, in a gap the one after it
    assign sel_idx = (state == ST_IDLE) ? '0 : idx + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    // next state and timer loads
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (sync_req) begin
                    state_nx = ST_SYNC_LO;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(SYNC_CYCLES - 1);
                end else if (reset_req) begin
                    state_nx = ST_RST_HI;
                    idx_nx   = '0;
                    tmr_load = 1'b1;
                    tmr_val  = pulse_m1;
                end
            end
            ST_SYNC_LO: begin
                if (tmr_zero) state_nx = ST_DONE;
            end
            ST_RST_HI: begin
                if (tmr_zero) begin
                    state_nx = ST_RST_LO;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(GAP_CYCLES - 1);
                end
            end
            ST_RST_LO: begin
                if (tmr_zero) begin
                    if (idx == LAST_IDX) begin
                        state_nx = ST_DONE;
                    end else begin
                        state_nx = ST_RST_HI;
                        idx_nx   = idx + 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = pulse_m1;
                    end
                end
            end
            ST_DONE: begin
                state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        busy       = 1'b1;
        done       = 1'b0;
        sync_n     = 1'b1;
        sclk_out   = 1'b0;
        seq_active = 1'b0;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_SYNC_LO: begin sync_n = 1'b0; seq_active = 1'b1; end
            ST_RST_HI:  begin sclk_out = 1'b1; seq_active = 1'b1; end
            ST_RST_LO:  seq_active = 1'b1;
            ST_DONE:    done = 1'b1;
            default:    busy = 1'b0;
        endcase
        sclk_own = busy;
    end

    cs_frame #(.USE_CS(USE_CS)) u_cs (
        .active (seq_active),
        .cs_n   (cs_n)
    );

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R6

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !sclk_own));  // R6

    AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_load && state != ST_IDLE) |-> tmr_zero);  // R5

    AST_SYNC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC_LO && !tmr_zero) |=> (state == ST_SYNC_LO));  // R5

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (idx <= LAST_IDX));  // R3

    AST_LAST_GAP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RST_LO && tmr_zero && idx == LAST_IDX) |=> done);  // R4

    AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_own |-> !sclk_out);  // R7

endmodule

// File: tb/tb_adc_maint_seq.sv
module tb_adc_maint_seq;

    localparam int SYNC_CYCLES = 1200;
    localparam int P0 = 256, P1 = 512, P2 = 1024;
    localparam int GAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_req = 1'b0;
    logic reset_req = 1'b0;
    logic busy, done, sync_n, sclk_out, sclk_own, cs_n;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_maint_seq dut (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .reset_req(reset_req),
        .busy(busy), .done(done), .sync_n(sync_n), .sclk_out(sclk_out),
        .sclk_own(sclk_own), .cs_n(cs_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, "busy idle", busy, 0);
        check(req, "done idle", done, 0);
        check(req, "sync_n idle", sync_n, 1);
        check(req, "sclk_out idle", sclk_out, 0);
        check(req, "sclk_own idle", sclk_own, 0);
        check(req, "cs_n idle", cs_n, 1);
    endtask

    // R1
    task automatic t_reset_state();
        @(negedge clk);
        check_idle("R1");
    endtask

    // sync run; optionally fire a reset request mid-way (R5) or together (R9)
    task automatic t_sync(input bit with_both, input bit poke_mid);
        int low_cnt = 0;
        int sclk_hi = 0;
        int cs_bad = 0;
        int own_bad = 0;
        int n = 0;
        @(negedge clk);
        sync_req = 1'b1;
        if (with_both) reset_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        reset_req = 1'b0;
        while (!done && n < 5000) begin
            if (!sync_n) low_cnt++;
            if (sclk_out) sclk_hi++;
            if (cs_n != 0) cs_bad++;
            if (!sclk_own || !busy) own_bad++;
            n++;
            if (poke_mid && n == 600) begin reset_req = 1'b1; sync_req = 1'b1; end
            if (poke_mid && n == 602) begin reset_req = 1'b0; sync_req = 1'b0; end
            @(negedge clk);
        end
        check(with_both ? "R9" : (poke_mid ? "R5" : "R2"), "sync low cycles", low_cnt, SYNC_CYCLES);
        check("R10", "sclk high during sync", sclk_hi, 0);
        check("R8", "cs_n high during sync", cs_bad, 0);
        check("R7", "sclk_own/busy dropped during sync", own_bad, 0);
        check("R6", "done seen", done, 1);
        check("R8", "cs_n in done cycle", cs_n, 1);
        check("R2", "sync_n in done cycle", sync_n, 1);
        @(negedge clk);
        check("R6", "done single", done, 0);
        check("R6", "busy after done", busy, 0);
        check_idle("R7");
    endtask

    // reset pattern; optionally poke sync mid-way (R5)
    task automatic t_reset_pat(input bit poke_mid);
        int hi_len[3];
        int lo_len[3];
        int hi_n = 0;
        int lo_n = 0;
        int run = 0;
        bit prev = 1'b1;
        int sync_bad = 0;
        int cs_bad = 0;
        int own_bad = 0;
        int n = 0;
        for (int i = 0; i < 3; i++) begin hi_len[i] = 0; lo_len[i] = 0; end
        @(negedge clk);
        reset_req = 1'b1;
        @(negedge clk);
        reset_req = 1'b0;
        while (!done && n < 5000) begin
            if (sclk_out == prev) begin
                run++;
            end else begin
                if (prev) begin if (hi_n < 3) hi_len[hi_n] = run; hi_n++; end
                else begin if (lo_n < 3) lo_len[lo_n] = run; lo_n++; end
                run = 1;
                prev = sclk_out;
            end
            if (!sync_n) sync_bad++;
            if (cs_n != 0) cs_bad++;
            if (!sclk_own || !busy) own_bad++;
            n++;
            if (poke_mid && n == 300) begin sync_req = 1'b1; reset_req = 1'b1; end
            if (poke_mid && n == 303) begin sync_req = 1'b0; reset_req = 1'b0; end
            @(negedge clk);
        end
        if (!prev) begin if (lo_n < 3) lo_len[lo_n] = run; lo_n++; end
        check("R3", "pulse count", hi_n, 3);
        check("R3", "pulse 0 length", hi_len[0], P0);
        check("R3", "pulse 1 length", hi_len[1], P1);
        check(poke_mid ? "R5" : "R3", "pulse 2 length", hi_len[2], P2);
        check("R4", "gap count", lo_n, 3);
        check("R4", "gap 0", lo_len[0], GAP);
        check("R4", "gap 1", lo_len[1], GAP);
        check("R4", "gap after last", lo_len[2], GAP);
        check("R10", "sync_n low during reset", sync_bad, 0);
        check("R8", "cs_n high during reset", cs_bad, 0);
        check("R7", "sclk_own dropped during reset", own_bad, 0);
        check("R6", "done seen", done, 1);
        check("R7", "sclk low in done", sclk_out, 0);
        @(negedge clk);
        check("R6", "done single", done, 0);
        check_idle("R6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_sync(1'b0, 1'b0);
        t_reset_pat(1'b0);
        t_sync(1'b0, 1'b1);
        t_reset_pat(1'b1);
        t_sync(1'b1, 1'b0);
        repeat (20) @(negedge clk);
        check_idle("R5");
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule